// File: doc/BRIEF.md
# Hash Core Register Interface Wrapper

This block is the 32-bit memory-mapped front end of an iterative hash engine of the SHA-512 family. A host reaches it through a simple strobe port made up of a select, a write enable, an 8-bit word address and 32-bit data in each direction, plus an error flag. Behind that port the block keeps a 1024-bit message block, a 512-bit chaining state, the variant selection, a repeat count and the command strobes. It feeds all of these to the engine and collects ready, valid and the new state when the engine finishes. The round logic is outside the scope of this block. A small behavioural stand-in with a fixed, documented mixing function takes its place so that the wrapper can be exercised end to end.

A host loads the message words and writes the control word to start a fresh hash or to continue one. It then polls status until the value is nonzero and reads the sixteen state words. The state words can also be written. A host that saved the chaining state earlier can put it back and continue with a further block. The full 512-bit state is always exposed, and cutting it down to the length of the chosen variant is the host's job.

Top module: `hregif_top`

## Requirements
- R1: After reset, status reads 0x1 (ready set, valid clear). Control, every block word and every state word read 0. The repeat count at 0x0a reads its default of 2.
- R2: Address 0x00 reads 0x68736877, 0x01 reads 0x72656766 and 0x02 reads 0x312e3030.
- R3: Control at 0x08 has these fields: bit 0 start fresh, bit 1 continue, bits 3:2 variant (0 = 512/224, 1 = 512/256, 2 = 384, 3 = 512) and bit 7 repeat enable. Writing bit 0 or bit 1 gives a single-cycle command to the engine, and both bits always read back as 0. When both bits are written, the start-fresh command wins.
- R4: Status at 0x09 has bit 0 = ready and bit 1 = valid. It reads 0 from the cycle after a command write until the result is stored. It then reads 0x3.
- R5: Block word at address 0x10+k holds bits 1023-32k down to 992-32k. State word at 0x40+k holds bits 511-32k down to 480-32k.
- R6: The stand-in engine treats the state as eight 64-bit lanes (lane 0 is the top lane). A fresh start loads lane i with 0x0123456789abcdef + (variant*8 + i). Each pass maps lane i to rotl1(lane_i ^ m_i ^ m_(i+8)) + 0x9e3779b97f4a7c15, where m_j is 64-bit block word j counted from the top.
- R7: State words written while ready is set are taken as the chaining state. A following continue command works from that state and not from the start values.
- R8: All sixteen state words hold the complete result for every variant. No word is cleared for the shorter variants.
- R9: The repeat count at 0x0a (8 bits) can be read and written. A start-fresh command with bit 7 set runs that many passes, and a count of 0 runs one pass. Without bit 7, and for every continue command, one pass runs.
- R10: err is high, in the same cycle, for a write to 0x00–0x02 or 0x09 or to any unmapped address, and for a read of an unmapped address. Such a read returns 0. err stays low for legal accesses and whenever select is low.
- R11: State-word writes made while ready is low are dropped.
- R12: Read data is valid in the same cycle that select is high with write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Access select, one cycle per access |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while sel is high and wr_en is low |
| err | output | 1 | Illegal access indicator for the current cycle |

## Verification
The assertions take two things for granted: every command pulse comes from a host write in the previous cycle, and the engine is idle whenever a command arrives that it should act on. The bench therefore issues a new control command only after status has returned nonzero. The one access it makes while the engine is busy is a state write, and that write is the case the dropping rule covers. All host accesses are single-cycle strobes driven on the falling clock edge, so select, write enable and address never change around the sampling edge.

// File: rtl/hregif_pkg.sv
package hregif_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 32;
  localparam int DIG_WORDS = 16;
  localparam int BLK_BITS  = WORD_W * BLK_WORDS;
  localparam int DIG_BITS  = WORD_W * DIG_WORDS;
  localparam int LANE_W    = 64;
  localparam int LANES     = DIG_BITS / LANE_W;
  localparam int BIDX_W    = $clog2(BLK_WORDS);
  localparam int DIDX_W    = $clog2(DIG_WORDS);

  localparam logic [7:0] A_ID0    = 8'h00;
  localparam logic [7:0] A_ID1    = 8'h01;
  localparam logic [7:0] A_VER    = 8'h02;
  localparam logic [7:0] A_CTRL   = 8'h08;
  localparam logic [7:0] A_STAT   = 8'h09;
  localparam logic [7:0] A_RPT    = 8'h0a;
  localparam logic [7:0] A_BLK_LO = 8'h10;
  localparam logic [7:0] A_BLK_HI = 8'h2f;
  localparam logic [7:0] A_DIG_LO = 8'h40;
  localparam logic [7:0] A_DIG_HI = 8'h4f;

  localparam int C_FRESH = 0;
  localparam int C_CONT  = 1;
  localparam int C_VAR   = 2;
  localparam int C_RPT   = 7;

  localparam logic [LANE_W-1:0] IV_BASE = 64'h0123456789abcdef;
  localparam logic [LANE_W-1:0] STEP_K  = 64'h9e3779b97f4a7c15;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_FLUSH = 2'd2
  } eng_st_e;
endpackage

// File: rtl/hregif_rst_sync.sv
module hregif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/hregif_engine_stub.sv
module hregif_engine_stub
  import hregif_pkg::*;
#(
  parameter int LAT  = 4,
  parameter int WF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_fresh,
  input  logic                go_cont,
  input  logic [1:0]          variant,
  input  logic [WF_W-1:0]     passes,
  input  logic [BLK_BITS-1:0] block,
  input  logic [DIG_BITS-1:0] state_in,
  output logic                ready,
  output logic                valid,
  output logic                done,
  output logic [DIG_BITS-1:0] result
);
  localparam int CYC_W = (LAT > 1) ? $clog2(LAT) : 1;

  eng_st_e             st_q, st_d;
  logic [DIG_BITS-1:0] work_q, work_d;
  logic [WF_W-1:0]     pass_q, pass_d;
  logic [CYC_W-1:0]    cyc_q, cyc_d;
  logic                valid_q, valid_d;

  function automatic logic [DIG_BITS-1:0] iv_fn(input logic [1:0] v);
    logic [DIG_BITS-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[DIG_BITS-1-LANE_W*i -: LANE_W] = IV_BASE + LANE_W'({v, 3'(i)});
    return r;
  endfunction

  function automatic logic [DIG_BITS-1:0] step_fn(input logic [DIG_BITS-1:0] s,
                                                  input logic [BLK_BITS-1:0] b);
    logic [DIG_BITS-1:0] r;
    logic [LANE_W-1:0]   x;
    for (int i = 0; i < LANES; i++) begin
      x = s[DIG_BITS-1-LANE_W*i -: LANE_W] ^ b[BLK_BITS-1-LANE_W*i -: LANE_W]
        ^ b[DIG_BITS-1-LANE_W*i -: LANE_W];
      r[DIG_BITS-1-LANE_W*i -: LANE_W] = {x[LANE_W-2:0], x[LANE_W-1]} + STEP_K;
    end
    return r;
  endfunction

  always_comb begin
    st_d    = st_q;
    work_d  = work_q;
    pass_d  = pass_q;
    cyc_d   = cyc_q;
    valid_d = valid_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (go_fresh || go_cont) begin
          work_d  = go_fresh ? iv_fn(variant) : state_in;
          pass_d  = (passes == '0) ? WF_W'(1) : passes;
          cyc_d   = CYC_W'(LAT - 1);
          valid_d = 1'b0;
          st_d    = ENG_RUN;
        end
      end
      ENG_RUN: begin
        if (cyc_q == '0) begin
          work_d = step_fn(work_q, block);
          if (pass_q == WF_W'(1)) begin
            st_d = ENG_FLUSH;
          end else begin
            pass_d = pass_q - WF_W'(1);
            cyc_d  = CYC_W'(LAT - 1);
          end
        end else begin
          cyc_d = cyc_q - CYC_W'(1);
        end
      end
      ENG_FLUSH: begin
        valid_d = 1'b1;
        st_d    = ENG_IDLE;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      work_q  <= '0;
      pass_q  <= '0;
      cyc_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      work_q  <= work_d;
      pass_q  <= pass_d;
      cyc_q   <= cyc_d;
      valid_q <= valid_d;
    end
  end

  assign ready  = (st_q == ENG_IDLE);
  assign valid  = valid_q;
  assign done   = (st_q == ENG_FLUSH);
  assign result = work_q;
endmodule

// File: rtl/hregif_regs.sv
module hregif_regs
  import hregif_pkg::*;
#(
  parameter int              WF_W       = 8,
  parameter logic [WF_W-1:0] WF_DEFAULT = 2,
  parameter logic [31:0]     ID_WORD0   = 32'h68736877,
  parameter logic [31:0]     ID_WORD1   = 32'h72656766,
  parameter logic [31:0]     VER_WORD   = 32'h312e3030
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic                wr_en,
  input  logic [7:0]          addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                err,
  input  logic                eng_ready,
  input  logic                eng_valid,
  input  logic                eng_done,
  input  logic [DIG_BITS-1:0] eng_result,
  output logic                go_fresh,
  output logic                go_cont,
  output logic [1:0]          variant,
  output logic [WF_W-1:0]     passes,
  output logic                stat_ready,
  output logic [BLK_BITS-1:0] blk_flat,
  output logic [DIG_BITS-1:0] dig_flat
);
  logic              wr, rd;
  logic              hit_id, hit_ctrl, hit_stat, hit_rpt, hit_blk, hit_dig;
  logic              legal_wr, legal_rd;
  logic [BIDX_W-1:0] bidx;
  logic [DIDX_W-1:0] didx;
  logic              stat_valid;

  logic [WORD_W-1:0] blk_q [BLK_WORDS];
  logic [WORD_W-1:0] dig_q [DIG_WORDS];
  logic [1:0]        var_q, var_d;
  logic              rpt_en_q, rpt_en_d;
  logic [WF_W-1:0]   rpt_q, rpt_d;
  logic              fresh_q, fresh_d, cont_q, cont_d;
  logic              ctrl_en, rpt_wen;

  // Address decode
  always_comb begin
    wr       = sel && wr_en;
    rd       = sel && !wr_en;
    hit_id   = (addr == A_ID0) || (addr == A_ID1) || (addr == A_VER);
    hit_ctrl = (addr == A_CTRL);
    hit_stat = (addr == A_STAT);
    hit_rpt  = (addr == A_RPT);
    hit_blk  = (addr >= A_BLK_LO) && (addr <= A_BLK_HI);
    hit_dig  = (addr >= A_DIG_LO) && (addr <= A_DIG_HI);
    bidx     = BIDX_W'(addr - A_BLK_LO);
    didx     = addr[DIDX_W-1:0];
    legal_wr = hit_ctrl || hit_rpt || hit_blk || hit_dig;
    legal_rd = legal_wr || hit_id || hit_stat;
    err      = (wr && !legal_wr) || (rd && !legal_rd);
  end

  // Status is masked while a command is on its way to the engine
  assign stat_ready = eng_ready && !fresh_q && !cont_q;
  assign stat_valid = eng_valid && !fresh_q && !cont_q;

  // Read path
  always_comb begin
    rdata = '0;
    if (rd) begin
      if      (addr == A_ID0) rdata = ID_WORD0;
      else if (addr == A_ID1) rdata = ID_WORD1;
      else if (addr == A_VER) rdata = VER_WORD;
      else if (hit_ctrl)      rdata = WORD_W'({rpt_en_q, 3'b000, var_q, 2'b00});
      else if (hit_stat)      rdata = WORD_W'({stat_valid, stat_ready});
      else if (hit_rpt)       rdata = WORD_W'(rpt_q);
      else if (hit_blk)       rdata = blk_q[bidx];
      else if (hit_dig)       rdata = dig_q[didx];
    end
  end

  // Control, command pulses and repeat count
  always_comb begin
    ctrl_en  = wr && hit_ctrl;
    rpt_wen  = wr && hit_rpt;
    fresh_d  = ctrl_en && wdata[C_FRESH];
    cont_d   = ctrl_en && wdata[C_CONT] && !wdata[C_FRESH];
    var_d    = ctrl_en ? wdata[C_VAR +: 2] : var_q;
    rpt_en_d = ctrl_en ? wdata[C_RPT]      : rpt_en_q;
    rpt_d    = rpt_wen ? wdata[WF_W-1:0]   : rpt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q  <= 1'b0;
      cont_q   <= 1'b0;
      var_q    <= 2'd0;
      rpt_en_q <= 1'b0;
      rpt_q    <= WF_DEFAULT;
    end else begin
      fresh_q  <= fresh_d;
      cont_q   <= cont_d;
      var_q    <= var_d;
      rpt_en_q <= rpt_en_d;
      rpt_q    <= rpt_d;
    end
  end

  // Message block words, one enable per word
  for (genvar k = 0; k < BLK_WORDS; k++) begin : g_blk
    logic blk_en;
    assign blk_en = wr && hit_blk && (bidx == BIDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_q[k] <= '0;
      else if (blk_en) blk_q[k] <= wdata;
    end
    assign blk_flat[BLK_BITS-1-WORD_W*k -: WORD_W] = blk_q[k];
  end

  // State words: engine result has priority, host load only while ready
  for (genvar k = 0; k < DIG_WORDS; k++) begin : g_dig
    logic              dig_en;
    logic [WORD_W-1:0] dig_d;
    assign dig_en = eng_done || (wr && hit_dig && stat_ready && (didx == DIDX_W'(k)));
    assign dig_d  = eng_done ? eng_result[DIG_BITS-1-WORD_W*k -: WORD_W] : wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig_q[k] <= '0;
      else if (dig_en) dig_q[k] <= dig_d;
    end
    assign dig_flat[DIG_BITS-1-WORD_W*k -: WORD_W] = dig_q[k];
  end

  assign go_fresh = fresh_q;
  assign go_cont  = cont_q;
  assign variant  = var_q;
  assign passes   = (fresh_q && rpt_en_q) ? rpt_q : WF_W'(1);
endmodule

// File: rtl/hregif_top.sv
module hregif_top
  import hregif_pkg::*;
#(
  parameter int              LAT        = 4,
  parameter int              WF_W       = 8,
  parameter logic [WF_W-1:0] WF_DEFAULT = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              err
);
  logic                rst_n_s;
  logic                go_fresh, go_cont;
  logic [1:0]          variant;
  logic [WF_W-1:0]     passes;
  logic                eng_ready, eng_valid, eng_done;
  logic [DIG_BITS-1:0] eng_result;
  logic                stat_ready;
  logic [BLK_BITS-1:0] blk_flat;
  logic [DIG_BITS-1:0] dig_flat;

  hregif_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_s)
  );

  hregif_regs #(.WF_W(WF_W), .WF_DEFAULT(WF_DEFAULT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sel        (sel),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .err        (err),
    .eng_ready  (eng_ready),
    .eng_valid  (eng_valid),
    .eng_done   (eng_done),
    .eng_result (eng_result),
    .go_fresh   (go_fresh),
    .go_cont    (go_cont),
    .variant    (variant),
    .passes     (passes),
    .stat_ready (stat_ready),
    .blk_flat   (blk_flat),
    .dig_flat   (dig_flat)
  );

  hregif_engine_stub #(.LAT(LAT), .WF_W(WF_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go_fresh (go_fresh),
    .go_cont  (go_cont),
    .variant  (variant),
    .passes   (passes),
    .block    (blk_flat),
    .state_in (dig_flat),
    .ready    (eng_ready),
    .valid    (eng_valid),
    .done     (eng_done),
    .result   (eng_result)
  );
endmodule

// File: rtl/hregif_checker.sv
module hregif_checker
  import hregif_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sel,
  input logic                wr_en,
  input logic                err,
  input logic [WORD_W-1:0]   rdata,
  input logic                go_fresh,
  input logic                go_cont,
  input logic                eng_ready,
  input logic                eng_done,
  input logic                stat_ready,
  input logic [DIG_BITS-1:0] dig_flat
);
  // R3: at most one command kind at a time (fresh start wins)
  a_r3_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_fresh, go_cont}));

  // R3: a command pulse is always caused by a host write one cycle earlier
  a_r3_cmd_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go_fresh || go_cont) |-> $past(sel && wr_en));

  // R4: an idle engine that sees a command is busy in the next cycle
  a_r4_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ((go_fresh || go_cont) && eng_ready) |=> !eng_ready);

  // R10: the error flag only appears during an access
  a_r10_err_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> sel);

  // R10: an illegal read returns zero
  a_r10_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && err) |-> (rdata == '0));

  // R11: state words hold while busy unless the engine is delivering
  a_r11_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_ready && !eng_done) |=> $stable(dig_flat));
endmodule

bind hregif_top hregif_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .sel        (sel),
  .wr_en      (wr_en),
  .err        (err),
  .rdata      (rdata),
  .go_fresh   (go_fresh),
  .go_cont    (go_cont),
  .eng_ready  (eng_ready),
  .eng_done   (eng_done),
  .stat_ready (stat_ready),
  .dig_flat   (dig_flat)
);

// File: tb/tb_hregif_top.sv
`timescale 1ns/1ps
module tb_hregif_top;
  logic        clk;
  logic        arst_n;
  logic        sel;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int n_chk;
  int n_fail;
  bit finished;

  logic [511:0] ms;        // model of the chaining state
  logic [7:0]   rpt_model; // model of the repeat count
  logic [31:0]  rd_v;
  logic         rd_e;

  hregif_top dut (
    .clk(clk), .arst_n(arst_n), .sel(sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // Table: [39:38] variant, [37] repeat enable, [36] 0 = fresh / 1 = continue, [31:0] seed
  localparam logic [39:0] VEC [6] = '{
    {2'd3, 1'b0, 1'b0, 4'h0, 32'h00000001},
    {2'd0, 1'b0, 1'b0, 4'h0, 32'h0000a5a5},
    {2'd0, 1'b0, 1'b1, 4'h0, 32'h00001234},
    {2'd2, 1'b1, 1'b0, 4'h0, 32'h00000000},
    {2'd1, 1'b0, 1'b1, 4'h0, 32'h00000077},
    {2'd3, 1'b1, 1'b1, 4'h0, 32'h00000099}
  };

  function automatic logic [31:0] blkw(input logic [31:0] seed, input int k);
    return seed ^ (32'h01000193 * 32'(k + 1));
  endfunction

  function automatic logic [511:0] m_iv(input logic [1:0] v);
    logic [511:0] r;
    for (int i = 0; i < 8; i++)
      r[511-64*i -: 64] = 64'h0123456789abcdef + 64'(v * 8 + i);
    return r;
  endfunction

  function automatic logic [511:0] m_step(input logic [511:0] s, input logic [1023:0] b);
    logic [511:0] r;
    logic [63:0]  x;
    for (int i = 0; i < 8; i++) begin
      x = s[511-64*i -: 64] ^ b[1023-64*i -: 64] ^ b[511-64*i -: 64];
      r[511-64*i -: 64] = {x[62:0], x[63]} + 64'h9e3779b97f4a7c15;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    #1 rd_e = err;
    @(posedge clk);
    #1 sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    #1 rd_v = rdata; rd_e = err;
    @(posedge clk);
    #1 sel = 1'b0;
  endtask

  task automatic read_state(output logic [511:0] d);
    for (int k = 0; k < 16; k++) begin
      hread(8'h40 + 8'(k));
      d[511-32*k -: 32] = rd_v;
    end
  endtask

  task automatic load_block(input logic [31:0] seed, output logic [1023:0] b);
    for (int k = 0; k < 32; k++) begin
      hwrite(8'h10 + 8'(k), blkw(seed, k));
      b[1023-32*k -: 32] = blkw(seed, k);
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    rd_v = 0;
    while (rd_v == 0 && n < 2000) begin
      hread(8'h09);
      n++;
    end
    chk({tag, " R4 status when finished"}, 512'(rd_v), 512'h3);
  endtask

  task automatic run_cmd(input logic [1:0] v, input logic rep, input logic cont,
                         input logic [1023:0] b, input logic [31:0] ctrl, input string tag);
    int p;
    logic [511:0] got;
    hwrite(8'h08, ctrl);
    hread(8'h09);
    chk({tag, " R4 status busy"}, 512'(rd_v), 512'h0);
    if (!cont) begin
      ms = m_iv(v);
      p  = rep ? ((rpt_model == 0) ? 1 : int'(rpt_model)) : 1;
    end else begin
      p  = 1;
    end
    for (int i = 0; i < p; i++) ms = m_step(ms, b);
    wait_done(tag);
    read_state(got);
    chk({tag, " R6 R8 full state"}, got, ms);
  endtask

  initial begin
    logic [1023:0] b;
    logic [511:0]  got;
    logic [511:0]  saved;
    n_chk = 0; n_fail = 0; finished = 0;
    sel = 0; wr_en = 0; addr = 0; wdata = 0;
    ms = '0; rpt_model = 8'd2;
    arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(8'h09); chk("R1 status", 512'(rd_v), 512'h1);
    hread(8'h08); chk("R1 control", 512'(rd_v), 512'h0);
    hread(8'h10); chk("R1 block word", 512'(rd_v), 512'h0);
    hread(8'h4f); chk("R1 state word", 512'(rd_v), 512'h0);
    hread(8'h0a); chk("R1 repeat default", 512'(rd_v), 512'h2);

    // R2 identification, R12 same-cycle read data
    hread(8'h00); chk("R2 R12 id0", 512'(rd_v), 512'h68736877);
    hread(8'h01); chk("R2 id1", 512'(rd_v), 512'h72656766);
    hread(8'h02); chk("R2 version", 512'(rd_v), 512'h312e3030);

    // Table walk: R5 R6 R8 R9
    foreach (VEC[i]) begin
      load_block(VEC[i][31:0], b);
      run_cmd(VEC[i][39:38], VEC[i][37], VEC[i][36], b,
              {24'h0, VEC[i][37], 3'b000, VEC[i][39:38], VEC[i][36], ~VEC[i][36]},
              $sformatf("R5 vec%0d", i));
    end

    // R5 block word order readback
    hread(8'h2f); chk("R5 last block word", 512'(rd_v), 512'(blkw(32'h99, 31)));

    // R3 both command bits: fresh start wins; pulse bits read 0
    load_block(32'h0badf00d, b);
    run_cmd(2'd1, 1'b0, 1'b0, b, 32'h0000_0007, "R3 both bits");
    hread(8'h08); chk("R3 control readback", 512'(rd_v), 512'h4);

    // R9 repeat count read/write, count of 0 means one pass
    hwrite(8'h0a, 32'h0000_0000); rpt_model = 8'd0;
    hread(8'h0a); chk("R9 repeat readback 0", 512'(rd_v), 512'h0);
    run_cmd(2'd3, 1'b1, 1'b0, b, 32'h0000_008d, "R9 zero count");
    hwrite(8'h0a, 32'h0000_0005); rpt_model = 8'd5;
    run_cmd(2'd2, 1'b1, 1'b0, b, 32'h0000_0089, "R9 five passes");

    // R11 state write during busy is dropped
    hwrite(8'h0a, 32'h0000_0028); rpt_model = 8'd40;
    hwrite(8'h08, 32'h0000_008d);
    ms = m_iv(2'd3);
    for (int i = 0; i < 40; i++) ms = m_step(ms, b);
    hwrite(8'h40, 32'hdeadbeef);
    hread(8'h09); chk("R11 status busy", 512'(rd_v), 512'h0);
    wait_done("R11");
    read_state(got);
    chk("R11 busy write dropped", got, ms);

    // R7 restore a saved chaining state, then continue
    saved = {16{32'h5a5a0000}} ^ 512'(64'h1122334455667788);
    for (int k = 0; k < 16; k++) hwrite(8'h40 + 8'(k), saved[511-32*k -: 32]);
    hread(8'h47); chk("R7 restored word", 512'(rd_v), 512'(saved[511-32*7 -: 32]));
    ms = saved;
    run_cmd(2'd3, 1'b0, 1'b1, b, 32'h0000_000e, "R7 continue from restored");

    // R10 error cases
    hwrite(8'h09, 32'h1);  chk("R10 write status err", 512'(rd_e), 512'h1);
    hwrite(8'h00, 32'h1);  chk("R10 write id err", 512'(rd_e), 512'h1);
    hwrite(8'h50, 32'h1);  chk("R10 write unmapped err", 512'(rd_e), 512'h1);
    hread(8'h30);
    chk("R10 read unmapped err", 512'(rd_e), 512'h1);
    chk("R10 read unmapped data", 512'(rd_v), 512'h0);
    hread(8'h05);          chk("R10 read hole err", 512'(rd_e), 512'h1);
    hread(8'h0a);          chk("R10 legal read no err", 512'(rd_e), 512'h0);
    hwrite(8'h10, 32'h3);  chk("R10 legal write no err", 512'(rd_e), 512'h0);
    @(negedge clk); addr = 8'h30; #1;
    chk("R10 no err without select", 512'(err), 512'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R4 run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule